// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block turns a captured start address and a configuration word into the stream of word addresses for a clocked burst read from a memory array. It also produces the cycle timing of that stream. A burst begins on the first rising clock edge where the active-low latch enable and chip enable are both low. On that edge the block captures the start address and the configuration. After a programmable number of latency cycles it presents one array word address per beat, together with a data-valid qualifier. It drives a WAIT output that is active whenever the data path does not hold a valid word.

The configuration word selects the following:
- the initial latency;
- a burst of four words, eight words or continuous;
- sequential or interleaved order;
- wrapping inside the aligned block or running straight past it;
- one- or two-cycle hold of each word;
- WAIT polarity.

In a continuous burst that starts off a four-word page boundary, the block inserts a single wait state the first time the address crosses a 64-word boundary. The host raises chip enable to stop a burst, or pulses latch enable again to start a new one.

Top module: `burst_read_seq`

## Requirements
- R1: While rst is high at a clock edge, the block returns to idle: data_vld is 0, wait_o is 0 (active-high polarity is assumed after reset) and arr_addr is 0.
- R2: A burst starts at the first rising edge where lat_n and ce_n are both low, provided they were not both low at the previous edge. That edge captures addr_in and cfg_in. From that edge, data_vld is 0 and WAIT is active.
- R3: The latency is L = cfg_in[13:11] read as an unsigned number, raised to 2 if smaller and lowered to 5 if larger. The first word is valid after the L-th rising edge following the start edge.
- R4: cfg_in[2:0] = 001 selects 4 words and 010 selects 8 words; every other code is continuous. After the last word of a 4- or 8-word burst, data_vld is 0 and WAIT stays active until an abort or a new start.
- R5: With cfg_in[9] = 1, each word stays on arr_addr with data_vld high for two cycles. With cfg_in[9] = 0, each word stays for one cycle.
- R6: With cfg_in[7] = 1 (sequential) and cfg_in[3] = 0 (wrap) in a 4- or 8-word burst, word n uses offset (s + n) mod B inside the B-aligned block that holds the start address, where s is the start offset. The upper bits stay unchanged.
- R7: With cfg_in[3] = 1 (no wrap), word n is the start address plus n.
- R8: With cfg_in[7] = 0 (interleaved), wrap and a 4- or 8-word length, word n uses offset s XOR n inside the B-aligned block. The upper bits stay unchanged.
- R9: Interleaved order requested together with continuous length or with no wrap has no effect: the sequence is the start address plus n.
- R10: A start address aligned to the burst length gives the same sequence with wrap and with no wrap.
- R11: In a continuous burst whose start address has bits [1:0] not equal to 0, one cycle with data_vld 0 and WAIT active precedes the first word whose address bits [5:0] are 0. No later crossing gets a stall, and a start with bits [1:0] = 0 gets none.
- R12: During a burst, WAIT is inactive exactly in the cycles where data_vld is high.
- R13: cfg_in[10] = 1 makes WAIT active high and 0 makes it active low. The polarity is captured at the burst start, and the idle level is the inactive level of the last captured polarity.
- R14: ce_n high at a rising edge ends the burst: data_vld is 0 and WAIT is inactive after that edge. A new start during a burst replaces it at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lat_n | input | 1 | Address latch enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| addr_in | input | AW | Burst start word address |
| cfg_in | input | CW | Configuration word (latency, length, order, wrap, hold, polarity) |
| arr_addr | output | AW | Word address presented to the array |
| data_vld | output | 1 | Marks the cycles where arr_addr holds a burst word |
| wait_o | output | 1 | WAIT indication with configured polarity |

## Verification
A corrupted latency count or hold flag shifts every later beat, so the very first word of a burst already lands in the wrong cycle. A bad block mask or order select shows on arr_addr at the second or third word, where wrap and interleave diverge from a linear count. A stale crossing flag or page test appears only at a 64-word boundary, as a stall that is missing or repeated. For that reason the continuous bursts run through two boundaries. The bench also compares WAIT in every cycle, so a phase stuck in the wrong state shows within one beat as a WAIT that disagrees with data_vld.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // configuration word field positions
  localparam int unsigned LEN_LSB   = 0;
  localparam int unsigned LEN_MSB   = 2;
  localparam int unsigned WRAP_BIT  = 3;
  localparam int unsigned ORDER_BIT = 7;
  localparam int unsigned HOLD_BIT  = 9;
  localparam int unsigned POL_BIT   = 10;
  localparam int unsigned LAT_LSB   = 11;
  localparam int unsigned LAT_MSB   = 13;

  localparam logic [2:0] LEN_CODE4 = 3'b001;
  localparam logic [2:0] LEN_CODE8 = 3'b010;

  localparam int unsigned LAT_MIN = 2;
  localparam int unsigned LAT_MAX = 5;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LAT,
    PH_DATA,
    PH_STALL,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic [2:0] lat;
    logic       two_cyc;
    logic       bounded;
    logic       len8;
    logic       ileave;
    logic       nowrap;
    logic       wait_hi;
  } bcfg_t;

  localparam bcfg_t CFG_RESET = '{
    lat:     3'd2,
    two_cyc: 1'b0,
    bounded: 1'b0,
    len8:    1'b0,
    ileave:  1'b0,
    nowrap:  1'b0,
    wait_hi: 1'b1
  };

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cfg_raw,
  output bcfg_t         cfg_dec
);

  logic [2:0] raw_lat;
  logic [2:0] len_code;
  logic       is_bounded;
  logic       unused_bits;

  assign unused_bits = ^cfg_raw;
  assign raw_lat     = cfg_raw[LAT_MSB:LAT_LSB];
  assign len_code    = cfg_raw[LEN_MSB:LEN_LSB];
  assign is_bounded  = (len_code == LEN_CODE4) || (len_code == LEN_CODE8);

  always_comb begin
    cfg_dec = CFG_RESET;
    if (raw_lat < 3'(LAT_MIN)) begin
      cfg_dec.lat = 3'(LAT_MIN);
    end else if (raw_lat > 3'(LAT_MAX)) begin
      cfg_dec.lat = 3'(LAT_MAX);
    end else begin
      cfg_dec.lat = raw_lat;
    end
    cfg_dec.two_cyc = cfg_raw[HOLD_BIT];
    cfg_dec.bounded = is_bounded;
    cfg_dec.len8    = (len_code == LEN_CODE8);
    cfg_dec.nowrap  = cfg_raw[WRAP_BIT];
    // interleave only honoured inside a wrapped, fixed-length burst
    cfg_dec.ileave  = ~cfg_raw[ORDER_BIT] & is_bounded & ~cfg_raw[WRAP_BIT];
    cfg_dec.wait_hi = cfg_raw[POL_BIT];
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  input  logic          bounded,
  input  logic          len8,
  input  logic          ileave,
  input  logic          nowrap,
  output logic [AW-1:0] word_addr
);

  localparam int OFF_MAX = 3;  // widest in-block offset (8 words)

  logic [AW-1:0] blk_mask;
  logic [AW-1:0] linear;
  logic [AW-1:0] mixed;
  logic          use_blk;

  assign blk_mask = len8 ? AW'(7) : AW'(3);
  assign linear   = base + idx;
  assign mixed    = ileave ? (base ^ idx) : linear;
  assign use_blk  = bounded & ~nowrap;

  for (genvar b = 0; b < AW; b++) begin : g_bit
    if (b < OFF_MAX) begin : g_off
      assign word_addr[b] = use_blk ? (blk_mask[b] ? mixed[b] : base[b]) : linear[b];
    end else begin : g_hi
      assign word_addr[b] = use_blk ? base[b] : linear[b];
    end
  end

endmodule

// File: rtl/burst_start_detect.sv
module burst_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic lat_n,
  input  logic ce_n,
  output logic start,
  output logic abort
);

  logic sel;
  logic sel_q;

  assign sel = ~lat_n & ~ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel;
    end
  end

  assign start = sel & ~sel_q;
  assign abort = ce_n;

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int BND_W  = 6,
  parameter int PAGE_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] cfg_in,
  output logic [AW-1:0] arr_addr,
  output logic          data_vld,
  output logic          wait_o
);

  logic          start_w;
  logic          abort_w;
  bcfg_t         cfg_new;
  bcfg_t         cfg_q;
  phase_e        phase;
  logic [2:0]    lat_cnt;
  logic          hold_q;
  logic          crossed_q;
  logic          vld_q;
  logic          wait_act_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] gen_idx;
  logic [AW-1:0] gen_addr;
  logic          last_word;
  logic          stall_hit;

  // plain views of captured configuration for the bound checker
  logic chk_pol;
  logic chk_two;
  logic chk_bnd;
  logic chk_nowrap;
  logic chk_len8;

  burst_start_detect u_start (
    .clk   (clk),
    .rst   (rst),
    .lat_n (lat_n),
    .ce_n  (ce_n),
    .start (start_w),
    .abort (abort_w)
  );

  burst_cfg_decode #(.CW(CW)) u_dec (
    .cfg_raw (cfg_in),
    .cfg_dec (cfg_new)
  );

  burst_addr_gen #(.AW(AW)) u_agen (
    .base      (base_q),
    .idx       (gen_idx),
    .bounded   (cfg_q.bounded),
    .len8      (cfg_q.len8),
    .ileave    (cfg_q.ileave),
    .nowrap    (cfg_q.nowrap),
    .word_addr (gen_addr)
  );

  assign gen_idx   = (phase == PH_LAT) ? '0 : idx_q + AW'(1);
  assign last_word = cfg_q.bounded && (idx_q == (cfg_q.len8 ? AW'(7) : AW'(3)));
  assign stall_hit = !cfg_q.bounded && !crossed_q
                   && (base_q[PAGE_W-1:0] != '0)
                   && (gen_addr[BND_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cfg_q      <= CFG_RESET;
      lat_cnt    <= '0;
      hold_q     <= 1'b0;
      crossed_q  <= 1'b0;
      vld_q      <= 1'b0;
      wait_act_q <= 1'b0;
      base_q     <= '0;
      idx_q      <= '0;
      addr_q     <= '0;
    end else if (start_w) begin
      phase      <= PH_LAT;
      cfg_q      <= cfg_new;
      lat_cnt    <= cfg_new.lat;
      hold_q     <= 1'b0;
      crossed_q  <= 1'b0;
      vld_q      <= 1'b0;
      wait_act_q <= 1'b1;
      base_q     <= addr_in;
      idx_q      <= '0;
    end else if (abort_w) begin
      phase      <= PH_IDLE;
      vld_q      <= 1'b0;
      wait_act_q <= 1'b0;
    end else begin
      case (phase)
        PH_LAT: begin
          if (lat_cnt == 3'd1) begin
            phase      <= PH_DATA;
            vld_q      <= 1'b1;
            wait_act_q <= 1'b0;
            addr_q     <= gen_addr;
            idx_q      <= gen_idx;
            hold_q     <= cfg_q.two_cyc;
          end else begin
            lat_cnt <= lat_cnt - 3'd1;
          end
        end
        PH_DATA: begin
          if (hold_q) begin
            hold_q <= 1'b0;
          end else if (last_word) begin
            phase      <= PH_DONE;
            vld_q      <= 1'b0;
            wait_act_q <= 1'b1;
          end else if (stall_hit) begin
            phase      <= PH_STALL;
            vld_q      <= 1'b0;
            wait_act_q <= 1'b1;
            crossed_q  <= 1'b1;
          end else begin
            vld_q  <= 1'b1;
            addr_q <= gen_addr;
            idx_q  <= gen_idx;
            hold_q <= cfg_q.two_cyc;
          end
        end
        PH_STALL: begin
          phase      <= PH_DATA;
          vld_q      <= 1'b1;
          wait_act_q <= 1'b0;
          addr_q     <= gen_addr;
          idx_q      <= gen_idx;
          hold_q     <= cfg_q.two_cyc;
        end
        default: begin
        end
      endcase
    end
  end

  assign arr_addr = addr_q;
  assign data_vld = vld_q;
  assign wait_o   = wait_act_q ~^ cfg_q.wait_hi;

  assign chk_pol    = cfg_q.wait_hi;
  assign chk_two    = cfg_q.two_cyc;
  assign chk_bnd    = cfg_q.bounded;
  assign chk_nowrap = cfg_q.nowrap;
  assign chk_len8   = cfg_q.len8;

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          start,
  input logic          data_vld,
  input logic          wait_o,
  input logic          pol_q,
  input logic          two_q,
  input logic          bnd_q,
  input logic          nowrap_q,
  input logic          len8_q,
  input logic [AW-1:0] arr_addr,
  input logic [AW-1:0] base_q
);

  logic [AW-1:0] blk_mask;
  assign blk_mask = len8_q ? AW'(7) : AW'(3);

  AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
    start |=> (!data_vld && (wait_o == pol_q))); // R2

  AST_VALID_NOT_WAIT: assert property (@(posedge clk) disable iff (rst)
    data_vld |-> (wait_o != pol_q)); // R12

  AST_CE_ABORT: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!data_vld && (wait_o != pol_q))); // R14

  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
    ($rose(data_vld) && two_q && !ce_n && !start) |=> (data_vld && $stable(arr_addr))); // R5

  AST_BLOCK_STAY: assert property (@(posedge clk) disable iff (rst)
    (data_vld && bnd_q && !nowrap_q) |-> (((arr_addr ^ base_q) & ~blk_mask) == '0)); // R6

endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .start    (start_w),
  .data_vld (data_vld),
  .wait_o   (wait_o),
  .pol_q    (chk_pol),
  .two_q    (chk_two),
  .bnd_q    (chk_bnd),
  .nowrap_q (chk_nowrap),
  .len8_q   (chk_len8),
  .arr_addr (arr_addr),
  .base_q   (base_q)
);

// File: tb/burst_read_seq_tb_top.sv
`timescale 1ns/1ps
module burst_read_seq_tb_top;

  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          lat_n;
  logic          ce_n;
  logic [AW-1:0] addr_in;
  logic [CW-1:0] cfg_in;
  logic [AW-1:0] arr_addr;
  logic          data_vld;
  logic          wait_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic          vld;
    logic [AW-1:0] addr;
    logic          wt;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #10 clk = ~clk;

  burst_read_seq #(.AW(AW), .CW(CW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .lat_n    (lat_n),
    .ce_n     (ce_n),
    .addr_in  (addr_in),
    .cfg_in   (cfg_in),
    .arr_addr (arr_addr),
    .data_vld (data_vld),
    .wait_o   (wait_o)
  );

  // lat: bits 13:11, pol: 10, hold: 9, sequential: 7, nowrap: 3, length: 2:0
  function automatic logic [15:0] mk_cfg(input int lat, input int len, input bit seq,
                                         input bit nw, input bit two, input bit pol);
    logic [15:0] c;
    c = '0;
    c[13:11] = 3'(lat);
    c[10]    = pol;
    c[9]     = two;
    c[7]     = seq;
    c[3]     = nw;
    c[2:0]   = 3'(len);
    return c;
  endfunction

  task automatic push_exp(input logic v, input logic [AW-1:0] a, input logic w, input string t);
    exp_t e;
    e.vld  = v;
    e.addr = a;
    e.wt   = w;
    e.tag  = t;
    exp_q.push_back(e);
  endtask

  // driver: starts a burst, pushes the expected per-cycle trace for ncyc cycles
  task automatic run_burst(input logic [AW-1:0] base, input logic [15:0] cw,
                           input int ncyc, input bit do_abort, input string tag);
    int lat;
    int blen;
    int n;
    int i;
    int off;
    int o2;
    int bi;
    bit pol;
    bit two;
    bit il;
    bit crossed;
    logic [AW-1:0] a;
    addr_in = base;
    cfg_in  = cw;
    lat_n   = 1'b0;
    ce_n    = 1'b0;
    @(posedge clk);
    lat = int'(cw[13:11]);
    if (lat < 2) lat = 2;
    if (lat > 5) lat = 5;
    blen = (cw[2:0] == 3'b001) ? 4 : ((cw[2:0] == 3'b010) ? 8 : 0);
    pol = cw[10];
    two = cw[9];
    il  = !cw[7] && !cw[3] && (blen != 0);
    bi  = int'(base);
    n = 0;
    i = 0;
    crossed = 0;
    for (int k = 0; k < lat && n < ncyc; k++) begin
      push_exp(1'b0, '0, pol, {tag, " latency R3"});
      n++;
    end
    while (n < ncyc) begin
      if (blen != 0 && i == blen) begin
        push_exp(1'b0, '0, pol, {tag, " end R4"});
        n++;
      end else begin
        if (blen == 0 || cw[3]) begin
          a = AW'(bi + i);
        end else begin
          off = bi % blen;
          o2  = il ? (off ^ i) : ((off + i) % blen);
          a   = AW'(bi - off + o2);
        end
        if (blen == 0 && !crossed && (bi % 4) != 0 && (int'(a) % 64) == 0) begin
          push_exp(1'b0, '0, pol, {tag, " stall R11"});
          n++;
          crossed = 1;
        end
        for (int h = 0; h < (two ? 2 : 1) && n < ncyc; h++) begin
          push_exp(1'b1, a, !pol, tag);
          n++;
        end
        i++;
      end
    end
    @(negedge clk);
    lat_n = 1'b1;
    repeat (ncyc - 1) @(negedge clk);
    if (do_abort) begin
      ce_n = 1'b1;
      @(posedge clk);
      push_exp(1'b0, '0, !pol, {tag, " abort R14"});
      @(negedge clk);
    end
  endtask

  // monitor: compares one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      cur = exp_q.pop_front();
      checks++;
      if (data_vld !== cur.vld || wait_o !== cur.wt ||
          (cur.vld && arr_addr !== cur.addr)) begin
        errors++;
        $display("FAIL %s R12: vld=%0b wait=%0b addr=%h expected vld=%0b wait=%0b addr=%h",
                 cur.tag, data_vld, wait_o, arr_addr, cur.vld, cur.wt, cur.addr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual hang, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst     = 1'b1;
    lat_n   = 1'b1;
    ce_n    = 1'b1;
    addr_in = '0;
    cfg_in  = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (data_vld !== 1'b0 || wait_o !== 1'b0 || arr_addr !== '0) begin
      errors++;
      $display("FAIL R1: vld=%0b wait=%0b addr=%h expected 0 0 0000", data_vld, wait_o, arr_addr);
    end
    // R2 R3 R4 R6: 4-word sequential wrap from offset 2
    run_burst(16'h0102, mk_cfg(2, 1, 1, 0, 0, 1), 9, 1, "R2 R6");
    // R8: 8-word interleaved wrap
    run_burst(16'h0035, mk_cfg(3, 2, 0, 0, 0, 1), 13, 1, "R8");
    // R7: 8-word no-wrap sequential
    run_burst(16'h0035, mk_cfg(2, 2, 1, 1, 0, 1), 12, 1, "R7");
    // R5: two-cycle hold, latency 5
    run_burst(16'h0108, mk_cfg(5, 1, 1, 0, 1, 1), 15, 1, "R5");
    // R11: continuous unaligned start crossing two 64-word boundaries
    run_burst(16'h003E, mk_cfg(4, 7, 1, 0, 0, 1), 76, 1, "R11");
    // R11: continuous page-aligned start, no stall
    run_burst(16'h003C, mk_cfg(2, 7, 1, 0, 0, 1), 12, 1, "R11 aligned");
    // R9: interleave ignored for continuous and for no-wrap
    run_burst(16'h0035, mk_cfg(2, 7, 0, 0, 0, 1), 14, 1, "R9 cont");
    run_burst(16'h0035, mk_cfg(2, 1, 0, 1, 0, 1), 9, 1, "R9 nowrap");
    // R10: aligned start, wrap vs no wrap
    run_burst(16'h0040, mk_cfg(3, 2, 1, 0, 0, 1), 13, 1, "R10 wrap");
    run_burst(16'h0040, mk_cfg(3, 2, 1, 1, 0, 1), 13, 1, "R10 nowrap");
    // R13: active-low WAIT
    run_burst(16'h0021, mk_cfg(2, 1, 1, 0, 0, 0), 9, 1, "R13");
    // R3: latency clamp low and high
    run_burst(16'h0010, mk_cfg(0, 1, 1, 0, 0, 1), 8, 1, "R3 low");
    run_burst(16'h0010, mk_cfg(7, 1, 1, 0, 0, 1), 11, 1, "R3 high");
    // R4: unlisted length code runs continuous
    run_burst(16'h0050, mk_cfg(2, 3, 1, 0, 0, 1), 10, 1, "R4 code011");
    // R14: restart in mid-burst
    run_burst(16'h0200, mk_cfg(3, 2, 1, 0, 0, 1), 6, 0, "R14 first");
    run_burst(16'h0305, mk_cfg(2, 1, 1, 0, 0, 1), 9, 1, "R14 restart");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d items left, expected 0", exp_q.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule